// File: doc/BRIEF.md
# Column Sigma-Delta Decimator with Digital Correlated Double Sampling

This block is the digital back end of one column of an image sensor readout built around a second-order sigma-delta modulator. It takes the modulator's 1-bit stream and filters it with two cascaded accumulators. The first counts ones. The second sums the first on every sample, so a constant input density produces a count that grows with the square of the elapsed samples. Each conversion phase integrates exactly `N_SAMPLES` samples (110 by default; at a 48 MHz sample clock this is about 2.3 µs).

A pixel is read in two phases. The reset-level phase starts from cleared accumulators. When it ends, the filter freezes and holds the reset count. A signal-phase start then loads the arithmetic negation of that count into the second accumulator: every bit is inverted and one is added. It also clears the first accumulator. After the signal phase, the second accumulator holds the signal count minus the reset count. That difference is published on `result` together with a one-cycle `result_valid` strobe. The subtraction for correlated double sampling is therefore folded into the filter's initial state, and no subtractor is needed after the filter.

The controller has four states:
- IDLE: waiting for a reset-phase start.
- RST_CONV: integrating the reset level.
- RST_DONE: filter frozen, holding the reset count.
- SIG_CONV: integrating the signal level.

It has six transitions:
- start_rst (IDLE to RST_CONV).
- rst_end (RST_CONV to RST_DONE, after the last sample).
- restart (RST_DONE to RST_CONV, a new reset-phase start).
- start_sig (RST_DONE to SIG_CONV).
- sig_end (SIG_CONV to IDLE, after the last sample, publishing the result).
- hold (staying in place when no event applies).

Top module: `sdcds_column`

## Requirements
- R1: While `rst_n` is low and after its release, `result_valid` is 0 and `result` is 0.
- R2: A start with `phase_sel`=0 in IDLE or RST_DONE clears both accumulators. The block then samples `mod_bit` on each of the next `N_SAMPLES` rising clock edges. On each sample, the first accumulator adds the bit, and the second accumulator adds the updated first accumulator.
- R3: A reset phase of all ones followed by a signal phase of all zeros yields `result` = -N(N+1)/2, which is -6105 for N=110, in two's complement.
- R4: After the reset phase's last sample, the filter is frozen until the next start: `mod_bit` activity while in RST_DONE has no effect on the result.
- R5: A start with `phase_sel`=1 in RST_DONE loads the bitwise inverse plus one of the held reset count into the second accumulator and clears the first accumulator. The final `result` therefore equals the signal-phase count minus the reset-phase count exactly.
- R6: `result_valid` is high for exactly one cycle, starting on the clock edge that takes the last signal-phase sample. `result` changes only on that edge and holds its value otherwise.
- R7: A start with `phase_sel`=1 while in IDLE is ignored: no conversion runs, `result_valid` stays 0 and `result` keeps its value.
- R8: Start pulses of either phase while a conversion is running are ignored and do not disturb the sample count or the accumulators.
- R9: A reset-phase start in RST_DONE discards the held reset count and begins a fresh reset conversion.
- R10: A reset phase of all zeros followed by a signal phase of all ones yields the full-scale positive result +N(N+1)/2, which is +6105 for N=110, with no overflow of the 14-bit signed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock; one modulator bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator output bit |
| start | input | 1 | One-cycle phase-start strobe |
| phase_sel | input | 1 | Phase chosen by `start`: 0 = reset level, 1 = signal level |
| result | output | 14 (RES_W) | Signed signal-minus-reset count |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The assertions assume that `start` is driven synchronously to `clk`. They also assume that `mod_bit` is a clean 0 or 1 on every edge, and that no more than `N_SAMPLES` ones can reach the first accumulator in one phase. That last assumption holds because the counter ends each phase. The bench changes every input only on the falling clock edge. It presents exactly one bit per rising edge during a phase, and it raises stray starts or toggles `mod_bit` only at chosen points: in the middle of a phase, in the frozen state, or in IDLE. Expected results come from a bench model that computes the same double sum over the same spread-density bit patterns.

// File: rtl/sdcds_pkg.sv
package sdcds_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RST_CONV = 2'd1,
        ST_RST_DONE = 2'd2,
        ST_SIG_CONV = 2'd3
    } conv_state_e;

    // Signed width that holds +/- n(n+1)/2, the largest double-sum count.
    function automatic int acc_width(input int n);
        return $clog2(n * (n + 1) / 2 + 1) + 1;
    endfunction

endpackage

// File: rtl/sdcds_ctrl.sv
module sdcds_ctrl
    import sdcds_pkg::*;
#(
    parameter int N_SAMPLES = 110,
    localparam int CNT_W = $clog2(N_SAMPLES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        phase_sel,
    output logic        clear,
    output logic        preload,
    output logic        integ_en,
    output logic        last_sig,
    output conv_state_e state
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_SAMPLES - 1);

    conv_state_e      st_nxt;
    logic [CNT_W-1:0] cnt;
    logic             at_last;

    assign at_last = (cnt == LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nxt;
    end

    // Transitions: start_rst, rst_end, restart, start_sig, sig_end, hold
    always_comb begin
        st_nxt = state;
        unique case (state)
            ST_IDLE:     if (start && !phase_sel) st_nxt = ST_RST_CONV;
            ST_RST_CONV: if (at_last)             st_nxt = ST_RST_DONE;
            ST_RST_DONE: if (start)               st_nxt = phase_sel ? ST_SIG_CONV : ST_RST_CONV;
            ST_SIG_CONV: if (at_last)             st_nxt = ST_IDLE;
            default:                              st_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        clear    = 1'b0;
        preload  = 1'b0;
        integ_en = 1'b0;
        last_sig = 1'b0;
        unique case (state)
            ST_IDLE:     clear = start && !phase_sel;
            ST_RST_CONV: integ_en = 1'b1;
            ST_RST_DONE: begin
                clear   = start && !phase_sel;
                preload = start && phase_sel;
            end
            ST_SIG_CONV: begin
                integ_en = 1'b1;
                last_sig = at_last;
            end
            default: ;
        endcase
    end

    // Sample counter within a phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (clear || preload) cnt <= '0;
        else if (integ_en)         cnt <= at_last ? '0 : cnt + CNT_W'(1);
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);  // R2

    AST_IDLE_SIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && phase_sel) |=> state == ST_IDLE);  // R7

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_en && !at_last) |=> (cnt == $past(cnt) + CNT_W'(1)));  // R8

endmodule

// File: rtl/sdcds_integ.sv
module sdcds_integ #(
    parameter int N_SAMPLES = 110,
    parameter bit EXACT_NEG = 1'b1,
    localparam int S1_W  = $clog2(N_SAMPLES + 1),
    localparam int ACC_W = sdcds_pkg::acc_width(N_SAMPLES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    preload,
    input  logic                    en,
    input  logic                    mod_bit,
    output logic [S1_W-1:0]         acc1,
    output logic signed [ACC_W-1:0] acc2,
    output logic signed [ACC_W-1:0] acc2_sum
);

    logic [S1_W-1:0]         s1_sum;
    logic [ACC_W-1:0]        s1_ext;
    logic signed [ACC_W-1:0] neg;

    assign s1_sum   = acc1 + S1_W'(mod_bit);
    assign s1_ext   = ACC_W'(s1_sum);
    assign acc2_sum = acc2 + $signed(s1_ext);

    // Negated reset count used as the signal-phase starting value
    generate
        if (EXACT_NEG) begin : g_exact
            assign neg = ~acc2 + ACC_W'(1);
        end else begin : g_ones
            assign neg = ~acc2;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc1 <= '0;
            acc2 <= '0;
        end else if (clear) begin
            acc1 <= '0;
            acc2 <= '0;
        end else if (preload) begin
            acc1 <= '0;
            acc2 <= neg;
        end else if (en) begin
            acc1 <= s1_sum;
            acc2 <= acc2_sum;
        end
    end

    AST_S1_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc1 <= S1_W'(N_SAMPLES));  // R2

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc1 == '0 && acc2 == '0));  // R2

endmodule

// File: rtl/sdcds_column.sv
module sdcds_column
    import sdcds_pkg::*;
#(
    parameter int N_SAMPLES = 110,
    parameter bit EXACT_NEG = 1'b1,
    localparam int RES_W = acc_width(N_SAMPLES),
    localparam int S1_W  = $clog2(N_SAMPLES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mod_bit,
    input  logic                    start,
    input  logic                    phase_sel,
    output logic signed [RES_W-1:0] result,
    output logic                    result_valid
);

    conv_state_e             st;
    logic                    clear, preload, integ_en, last_sig;
    logic [S1_W-1:0]         acc1;
    logic signed [RES_W-1:0] acc2, acc2_sum;

    sdcds_ctrl #(.N_SAMPLES(N_SAMPLES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .phase_sel (phase_sel),
        .clear     (clear),
        .preload   (preload),
        .integ_en  (integ_en),
        .last_sig  (last_sig),
        .state     (st)
    );

    sdcds_integ #(.N_SAMPLES(N_SAMPLES), .EXACT_NEG(EXACT_NEG)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .preload  (preload),
        .en       (integ_en),
        .mod_bit  (mod_bit),
        .acc1     (acc1),
        .acc2     (acc2),
        .acc2_sum (acc2_sum)
    );

    // Publish the last signal-phase sum on the edge of the final sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= last_sig;
            if (last_sig) result <= acc2_sum;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);  // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));  // R6

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RST_DONE && !start) |=> $stable(acc2));  // R4

    AST_PRELOAD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        preload |=> (acc1 == '0 && st == ST_SIG_CONV));  // R5

endmodule

// File: tb/sdcds_column_test.sv
module sdcds_column_test;

    localparam int CLK_NS = 10;
    localparam int N      = 110;
    localparam int W      = 14;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                mod_bit = 1'b0;
    logic                start = 1'b0;
    logic                phase_sel = 1'b0;
    logic signed [W-1:0] result;
    logic                result_valid;

    int checks = 0;
    int fails  = 0;

    always #(CLK_NS/2) clk = ~clk;

    sdcds_column uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mod_bit      (mod_bit),
        .start        (start),
        .phase_sel    (phase_sel),
        .result       (result),
        .result_valid (result_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // d ones spread evenly over N samples
    function automatic int pbit(input int d, input int k);
        return ((k + 1) * d) / N - (k * d) / N;
    endfunction

    function automatic int model(input int d);
        int s1 = 0;
        int s2 = 0;
        for (int k = 0; k < N; k++) begin
            s1 += pbit(d, k);
            s2 += s1;
        end
        return s2;
    endfunction

    // Start strobe, then one bit per edge; returns at the falling edge after the last sample
    task automatic convert(input logic ph, input int d, input logic inject);
        @(negedge clk);
        start = 1'b1; phase_sel = ph; mod_bit = 1'b0;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            start     = inject && (k == 50 || k == 51);
            phase_sel = (k == 51);
            mod_bit   = (pbit(d, k) != 0);
        end
        @(negedge clk);
        start = 1'b0; phase_sel = 1'b0; mod_bit = 1'b0;
    endtask

    task automatic idle(input int n, input logic b);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mod_bit = b;
        end
        @(negedge clk);
        mod_bit = 1'b0;
    endtask

    task automatic check_done(input string req, input int exp);
        chk({req, " result"}, int'(result), exp);
        chk("R6 valid on last sample", int'(result_valid), 1);
        @(negedge clk);
        chk("R6 valid one cycle", int'(result_valid), 0);
        chk("R6 result held", int'(result), exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(result_valid), 0);
        chk("R1 result in reset", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", int'(result_valid), 0);
    endtask

    task automatic t_pair(input string req, input int dr, input int ds);
        convert(1'b0, dr, 1'b0);
        idle(3, 1'b0);
        convert(1'b1, ds, 1'b0);
        check_done(req, model(ds) - model(dr));
    endtask

    task automatic t_frozen();
        convert(1'b0, 30, 1'b0);
        idle(20, 1'b1);
        convert(1'b1, 70, 1'b0);
        check_done("R4 frozen", model(70) - model(30));
    endtask

    task automatic t_inject();
        convert(1'b0, 20, 1'b1);
        convert(1'b1, 90, 1'b1);
        check_done("R8 busy starts", model(90) - model(20));
    endtask

    task automatic t_idle_sig();
        int prev;
        prev = int'(result);
        convert(1'b1, 100, 1'b0);
        chk("R7 no valid", int'(result_valid), 0);
        chk("R7 result kept", int'(result), prev);
        @(negedge clk);
        chk("R7 still no valid", int'(result_valid), 0);
    endtask

    task automatic t_restart();
        convert(1'b0, 100, 1'b0);
        convert(1'b0, 10, 1'b0);
        convert(1'b1, 60, 1'b0);
        check_done("R9 restart", model(60) - model(10));
    endtask

    initial begin
        t_reset();
        t_pair("R5 mid", 40, 80);
        t_pair("R2 sparse", 7, 23);
        t_pair("R5 equal", 55, 55);
        t_pair("R3 full negative", 110, 0);
        chk("R3 exact value", int'(result), -6105);
        t_pair("R10 full positive", 0, 110);
        chk("R10 exact value", int'(result), 6105);
        t_frozen();
        t_inject();
        t_idle_sig();
        t_restart();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule